// File: doc/BRIEF.md
# Dual PWM Generator with Channel Router

This block contains two independent pulse-width generators and a router that sends their waveforms to a bank of output channels. Each generator has an 8-bit duty value, a 2-bit rate code and a 1-bit range bit. All three are written through a simple single-cycle register-write port. Both generators run from one shared base-tick enable. Each one advances a 10-bit phase accumulator with two fractional bits. Because of the fractional bits, one of the six period settings gives the non-integer ratio of 51.2 ticks.

Duty and rate writes first land in a shadow copy. They move to the running copy only when the accumulator wraps, that is, at the period boundary. This also happens when the generator is at 0 % or is forced to 100 %, so a waveform never shows a half-applied change. Rate code 3 forces the output to a constant high level, because the 8-bit duty alone stops at 255/256.

The router has a per-channel enable word and a per-channel generator-select word. A channel that is not enabled copies its bit of a direct-control input.

Top module: `pwm_dual_router`

## Requirements
- R1: After reset both generator outputs are low (duty 0), and every channel output equals its bit of `directIn`.
- R2: A write with `wrEn` high stores `wrData` into one register, chosen by `wrAddr`:
  - 0: generator 0 duty.
  - 1: generator 0 config, with rate code in bits [1:0] and range in bit [2].
  - 2: generator 1 duty.
  - 3: generator 1 config, same layout as address 1.
  - 4: channel enable word.
  - 5: channel select word.
- R3: A written duty or config value takes effect only at the next period boundary. Until then the running waveform keeps its old duty, including when the old duty is 0 % or 100 %.
- R4: With range 0, rate codes 0, 1 and 2 give periods of 1024, 512 and 256 ticks. The high times are 4·duty, 2·duty and duty ticks, and the output is high at the start of each period.
- R5: With range 1, rate codes 0 and 1 give periods of 128 and 64 ticks. The high times are ceil(duty/2) and ceil(duty/4) ticks.
- R6: With range 1 and rate code 2, any five consecutive periods together last exactly 256 ticks and contain exactly `duty` high ticks.
- R7: Duty 255 at a 256-tick period gives 255 high ticks and 1 low tick. Duty 0 keeps the output permanently low.
- R8: Rate code 3 holds the output constant high whatever the duty value. Period boundaries keep occurring at the last valid rate, so a pending write made during 100 % is still applied.
- R9: The phase advances only in clock cycles where `tickEn` is high. With `tickEn` high every second cycle, all periods double in clock cycles.
- R10: A channel whose enable bit is 1 outputs generator 0 when its select bit is 0 and generator 1 when its select bit is 1. A channel whose enable bit is 0 outputs its `directIn` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base-tick enable shared by both generators |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| directIn | input | NUM_CH | Static level for channels not routed to a generator |
| pwmOut | output | 2 | Raw waveform of generator 0 (bit 0) and generator 1 (bit 1) |
| chanOut | output | NUM_CH | Routed channel outputs |

## Verification
A register write and a period boundary can fall on the same tick. The bench provokes this case as follows:
- It lets a generator run at a 256-tick period and writes a new duty in the middle of a high-free stretch.
- It then checks that the output stays low until the accumulator wraps.
- It measures the following period against the new duty.

The same collision is judged at the 100 % forced level. There, a duty write and a rate write are made while the output is constant high, and the bench checks that a normal waveform appears once a boundary passes.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int NUM_GEN = 2;
  localparam int DUTY_W  = 8;
  localparam int FRAC_W  = 2;            // two fractional bits make the 51.2 ratio exact
  localparam int ACC_W   = DUTY_W + FRAC_W;
  localparam int STEP_W  = 5;            // largest step is 20 quarter-ticks
  localparam logic [1:0] CODE_FULL = 2'b11;

  typedef struct packed {
    logic [NUM_GEN-1:0] loadDuty;
    logic [NUM_GEN-1:0] loadCfg;
    logic               loadEnable;
    logic               loadSelect;
  } wrStrobe_t;

  function automatic logic [STEP_W-1:0] stepFor(input logic [1:0] code, input logic range);
    logic [STEP_W-1:0] s;
    if (!range)             s = STEP_W'(1) << code;
    else if (code == 2'b10) s = STEP_W'(20);
    else                    s = STEP_W'(8) << code;
    return s;
  endfunction
endpackage

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strobe
);
  localparam int ENABLE_ADDR = 2 * NUM_GEN;
  localparam int SELECT_ADDR = 2 * NUM_GEN + 1;

  always_comb begin
    strobe = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      strobe.loadDuty[g] = wrEn && (wrAddr == ADDR_W'(2 * g));
      strobe.loadCfg[g]  = wrEn && (wrAddr == ADDR_W'(2 * g + 1));
    end
    strobe.loadEnable = wrEn && (wrAddr == ADDR_W'(ENABLE_ADDR));
    strobe.loadSelect = wrEn && (wrAddr == ADDR_W'(SELECT_ADDR));
  end

  // one register per write
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadDuty, strobe.loadCfg, strobe.loadEnable, strobe.loadSelect}));
endmodule

// File: rtl/pwm_gen_core.sv
`timescale 1ns/1ps
module pwm_gen_core
  import pwm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              loadDuty,
  input  logic              loadCfg,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmHigh
);
  logic [DUTY_W-1:0] shadowDuty, activeDuty;
  logic [1:0]        shadowCode, activeCode;
  logic              shadowRange;
  logic [STEP_W-1:0] rateStep;
  logic [ACC_W-1:0]  phaseAcc;
  logic [ACC_W:0]    phaseSum;
  logic              wrap;

  assign phaseSum = {1'b0, phaseAcc} + (ACC_W + 1)'(rateStep);
  assign wrap     = tickEn && phaseSum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowDuty  <= '0;
      activeDuty  <= '0;
      shadowCode  <= '0;
      activeCode  <= '0;
      shadowRange <= 1'b0;
      rateStep    <= STEP_W'(1);
      phaseAcc    <= '0;
    end else begin
      if (loadDuty) shadowDuty <= wrData[DUTY_W-1:0];
      if (loadCfg) begin
        shadowCode  <= wrData[1:0];
        shadowRange <= wrData[2];
      end
      if (tickEn) phaseAcc <= phaseSum[ACC_W-1:0];
      if (wrap) begin
        activeDuty <= shadowDuty;
        activeCode <= shadowCode;
        if (shadowCode != CODE_FULL) rateStep <= stepFor(shadowCode, shadowRange);
      end
    end
  end

  assign pwmHigh = (activeCode == CODE_FULL) || (phaseAcc[ACC_W-1:FRAC_W] < activeDuty);

  assert_duty_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(activeDuty));
  assert_duty_loaded_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> activeDuty == $past(shadowDuty));
  assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(phaseAcc));
  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    pwmHigh |-> (activeDuty != '0 || activeCode == CODE_FULL));
endmodule

// File: rtl/pwm_datapath.sv
`timescale 1ns/1ps
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  wrStrobe_t          strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_CH-1:0]  directIn,
  output logic [NUM_GEN-1:0] pwmOut,
  output logic [NUM_CH-1:0]  chanOut
);
  logic [NUM_CH-1:0] chanEnable, chanSelect;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwm_gen_core #(.DATA_W(DATA_W)) core_i (
      .clk(clk), .rstN(rstN), .tickEn(tickEn),
      .loadDuty(strobe.loadDuty[g]), .loadCfg(strobe.loadCfg[g]),
      .wrData(wrData), .pwmHigh(pwmOut[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnable <= '0;
      chanSelect <= '0;
    end else begin
      if (strobe.loadEnable) chanEnable <= wrData[NUM_CH-1:0];
      if (strobe.loadSelect) chanSelect <= wrData[NUM_CH-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanOut[c] = chanEnable[c] ? pwmOut[chanSelect[c]] : directIn[c];
  end

  assert_enable_written_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEnable |=> chanEnable == $past(wrData[NUM_CH-1:0]));
endmodule

// File: rtl/pwm_dual_router.sv
`timescale 1ns/1ps
module pwm_dual_router
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] directIn,
  output logic [1:0]        pwmOut,
  output logic [NUM_CH-1:0] chanOut
);
  wrStrobe_t strobe;

  pwm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  pwm_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe), .wrData(wrData),
    .directIn(directIn), .pwmOut(pwmOut), .chanOut(chanOut)
  );
endmodule

// File: tb/pwm_dual_router_tb.sv
`timescale 1ns/1ps
module pwm_dual_router_tb_top;
  localparam int NCH = 8;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b1, wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [NCH-1:0] directIn = '0;
  logic [1:0] pwmOut;
  logic [NCH-1:0] chanOut;
  bit halfRate = 1'b0;
  int checks = 0, errors = 0;

  pwm_dual_router dut_i (.clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .directIn(directIn), .pwmOut(pwmOut), .chanOut(chanOut));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tickEn = halfRate ? ~tickEn : 1'b1;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic getRise(input int g);
    logic prev = pwmOut[g];
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && pwmOut[g]) return;
      prev = pwmOut[g];
    end
  endtask

  // starts at a rise sample (waits for one unless atRise), counts n periods
  task automatic measure(input int g, input int n, input bit atRise, output int hi, output int per);
    int rises = 0;
    logic prev;
    if (!atRise) getRise(g);
    hi = 1; per = 1; prev = 1'b1;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (!prev && pwmOut[g]) begin
        rises++;
        if (rises == n) return;
      end
      prev = pwmOut[g];
      per++;
      if (pwmOut[g]) hi++;
    end
  endtask

  task automatic countHigh(input int g, input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut[g]) hi++;
    end
  endtask

  task automatic testReset();
    directIn = 8'h5A;
    @(negedge clk);
    check("R1 chanOut follows directIn", int'(chanOut), 8'h5A);
    check("R1 pwmOut low", int'(pwmOut), 0);
  endtask

  task automatic testRange0();
    int hi, per;
    wr(3'd0, 8'd50);
    for (int c = 0; c < 3; c++) begin
      wr(3'd1, 8'(c));
      getRise(0);
      measure(0, 1, 1'b0, hi, per);
      check($sformatf("R4 period code %0d", c), per, 1024 >> c);
      check($sformatf("R4 high code %0d", c), hi, 200 >> c);
    end
  endtask

  task automatic testRange1();
    int hi, per;
    wr(3'd1, 8'b100);
    getRise(0);
    measure(0, 1, 1'b0, hi, per);
    check("R5 period 128", per, 128);
    check("R5 high 128", hi, 25);
    wr(3'd1, 8'b101);
    getRise(0);
    measure(0, 1, 1'b0, hi, per);
    check("R5 period 64", per, 64);
    check("R5 high 64", hi, 13);
    wr(3'd0, 8'd100);
    wr(3'd1, 8'b110);
    getRise(0);
    measure(0, 5, 1'b0, hi, per);
    check("R6 five periods span", per, 256);
    check("R6 five periods high", hi, 100);
  endtask

  task automatic testExtremes();
    int hi, per;
    wr(3'd0, 8'd255);
    wr(3'd1, 8'b010);
    getRise(0);
    measure(0, 1, 1'b0, hi, per);
    check("R7 duty 255 period", per, 256);
    check("R7 duty 255 high", hi, 255);
    wr(3'd0, 8'd0);
    repeat (600) @(negedge clk);
    countHigh(0, 600, hi);
    check("R7 duty 0 never high", hi, 0);
    wr(3'd1, 8'b011);
    repeat (600) @(negedge clk);
    countHigh(0, 1100, hi);
    check("R8 forced full high", hi, 1100);
    wr(3'd0, 8'd128);
    wr(3'd1, 8'b010);
    measure(0, 1, 1'b0, hi, per);
    check("R8 pending update applied period", per, 256);
    check("R8 pending update applied high", hi, 128);
  endtask

  task automatic testDeferral();
    int early = 0, hi, per;
    logic prev;
    getRise(0);
    repeat (150) @(negedge clk);
    wr(3'd0, 8'd200);
    prev = pwmOut[0];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!prev && pwmOut[0]) break;
      if (pwmOut[0]) early++;
      prev = pwmOut[0];
    end
    check("R3 old duty kept until boundary", early, 0);
    measure(0, 1, 1'b1, hi, per);
    check("R3 new duty period", per, 256);
    check("R3 new duty high", hi, 200);
  endtask

  task automatic testHalfTick();
    int hi, per;
    halfRate = 1'b1;
    getRise(0);
    measure(0, 1, 1'b0, hi, per);
    check("R9 half tick period", per, 512);
    check("R9 half tick high", hi, 400);
    halfRate = 1'b0;
  endtask

  task automatic testRouting();
    int hi, per;
    logic [7:0] en, sel, expv;
    wr(3'd2, 8'd32);
    wr(3'd3, 8'b101);
    getRise(1);
    measure(1, 1, 1'b0, hi, per);
    check("R2 gen1 period", per, 64);
    check("R2 gen1 high", hi, 8);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'b011);
    repeat (600) @(negedge clk);
    check("R10 gen levels", int'(pwmOut), 1);
    en = 8'h0F; sel = 8'h0A; directIn = 8'hA5;
    wr(3'd4, en);
    wr(3'd5, sel);
    @(negedge clk);
    expv = (en & ((sel & {8{pwmOut[1]}}) | (~sel & {8{pwmOut[0]}}))) | (~en & directIn);
    check("R10 mapped channels", int'(chanOut), int'(expv));
    check("R10 mapped channels literal", int'(chanOut), 8'hA5);
    directIn = 8'h5A;
    @(negedge clk);
    check("R10 direct channels follow input", int'(chanOut[7:4]), 4'h5);
    check("R10 enabled channels ignore input", int'(chanOut[3:0]), 4'h5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRange0();
    testRange1();
    testExtremes();
    testDeferral();
    testHalfTick();
    testRouting();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule